// File: doc/BRIEF.md
# Move-Machine ALU with Shared Operand Pre-Stage

This block is the arithmetic unit of a processor whose only instruction is a move between bus endpoints. Two operand registers (A and B) and a control word held in the immediate register feed it. It drives two results at once. The first is a data word, which the bus reads whenever the ALU is named as a move source. The second is a one-bit predicate, which decides whether a conditional move takes effect.

Before either function sees operand B, B passes through a pre-stage. The pre-stage can keep B as it is, replace it with the upper part of the control word, or shift it one place in either direction. It can then invert the result. The low three control bits are read twice: once as the data function code and once as the test code. So one control word always defines both a data result and a predicate.

The block is purely combinational. Registers, bus steering and sequencing belong to the surrounding core. The external sense condition is tied inactive inside the block.

Top module: `mm_alu`

## Requirements
- R1: With control bits [6:5] = 00, the effective B equals the B operand unchanged.
- R2: With control bits [6:5] = 01, the effective B is the whole control word shifted right by 7, with zeros filling from the top.
- R3: With control bits [6:5] = 10, the effective B is B shifted right by one place. With bits [6:5] = 11, it is B shifted left by one place. Both shifts fill with zero.
- R4: Control bit 3 set inverts every bit of the effective B, after the selection of R1 to R3.
- R5: Function code 0 (control bits [2:0]) returns A plus effective B plus control bit 4 as carry-in, wrapped modulo 2^32, with no carry-out.
- R6: Function codes 1 to 5 return, in order: A AND B, A OR B, A XOR B, A alone, and effective B alone.
- R7: Function codes 6 and 7 return zero, whatever the operands are.
- R8: Test code 0 is true exactly when A is zero. Test code 1 is true exactly when the effective B is zero.
- R9: Test codes 2, 3 and 4 compare A with the effective B as unsigned numbers, and are true for A greater, A equal and A less respectively.
- R10: Test code 5 is true when bit 0 of the effective B is set. Test code 6 is true when bit 31 of the effective B is set.
- R11: Test code 7 (the external sense condition) is always false.
- R12: Both outputs follow any input change within the same clock cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctrl_i | input | 32 | Control word taken from the immediate register |
| opa_i | input | 32 | Operand register A |
| opb_i | input | 32 | Operand register B, before the pre-stage |
| res_o | output | 32 | Data result, read as a bus source |
| pred_o | output | 1 | Test result that gates conditional moves |

## Verification
The data function and the test function are always evaluated together. Both read the same three code bits and the same pre-stage output, so a wrong pre-stage setting corrupts both results in the same cycle. The bench provokes this by sweeping all 128 values of the low seven control bits against several operand pairs, including equal, zero and all-ones operands. On every clock it judges the data word and the predicate separately against a behavioural model.

// File: rtl/mm_alu_pkg.sv
package mm_alu_pkg;

    localparam int unsigned CODE_W = 3;

    typedef enum logic [1:0] {
        BSEL_RAW = 2'b00,
        BSEL_IMM = 2'b01,
        BSEL_SHR = 2'b10,
        BSEL_SHL = 2'b11
    } bsel_e;

    typedef enum logic [CODE_W-1:0] {
        DF_ADD  = 3'd0,
        DF_AND  = 3'd1,
        DF_OR   = 3'd2,
        DF_XOR  = 3'd3,
        DF_PASA = 3'd4,
        DF_PASB = 3'd5,
        DF_NIL6 = 3'd6,
        DF_NIL7 = 3'd7
    } dfn_e;

    typedef enum logic [CODE_W-1:0] {
        TS_AZERO = 3'd0,
        TS_BZERO = 3'd1,
        TS_AGT   = 3'd2,
        TS_AEQ   = 3'd3,
        TS_ALT   = 3'd4,
        TS_BLSB  = 3'd5,
        TS_BMSB  = 3'd6,
        TS_SENSE = 3'd7
    } tfn_e;

    typedef struct packed {
        bsel_e             bsel;
        logic              cin;
        logic              inv;
        logic [CODE_W-1:0] code;
    } ctl_t;

    function automatic ctl_t ctl_decode(input logic [6:0] lo);
        ctl_t c;
        c.bsel = bsel_e'(lo[6:5]);
        c.cin  = lo[4];
        c.inv  = lo[3];
        c.code = lo[2:0];
        return c;
    endfunction

endpackage

// File: rtl/mm_bpre.sv
module mm_bpre
    import mm_alu_pkg::*;
#(
    parameter int unsigned W         = 32,
    parameter int unsigned IMM_SHIFT = 7
) (
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] ctrl_i,
    input  bsel_e        bsel_i,
    input  logic         inv_i,
    output logic [W-1:0] effb_o
);

    logic [W-1:0] sel_d;

    always_comb begin
        unique case (bsel_i)
            BSEL_RAW: sel_d = opb_i;
            BSEL_IMM: sel_d = ctrl_i >> IMM_SHIFT;
            BSEL_SHR: sel_d = opb_i >> 1;
            BSEL_SHL: sel_d = opb_i << 1;
            default:  sel_d = opb_i;
        endcase
    end

    assign effb_o = inv_i ? ~sel_d : sel_d;

endmodule

// File: rtl/mm_dfn.sv
module mm_dfn
    import mm_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic              cin_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [W-1:0]      res_o
);

    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] xor_v;
    logic [W-1:0] sum_v;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_v[i] = a_i[i] & b_i[i];
        assign or_v[i]  = a_i[i] | b_i[i];
        assign xor_v[i] = a_i[i] ^ b_i[i];
    end

    assign sum_v = a_i + b_i + {{(W-1){1'b0}}, cin_i};

    always_comb begin
        unique case (dfn_e'(code_i))
            DF_ADD:  res_o = sum_v;
            DF_AND:  res_o = and_v;
            DF_OR:   res_o = or_v;
            DF_XOR:  res_o = xor_v;
            DF_PASA: res_o = a_i;
            DF_PASB: res_o = b_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/mm_tfn.sv
module mm_tfn
    import mm_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              sense_i,
    output logic              pred_o
);

    always_comb begin
        unique case (tfn_e'(code_i))
            TS_AZERO: pred_o = (a_i == '0);
            TS_BZERO: pred_o = (b_i == '0);
            TS_AGT:   pred_o = (a_i > b_i);
            TS_AEQ:   pred_o = (a_i == b_i);
            TS_ALT:   pred_o = (a_i < b_i);
            TS_BLSB:  pred_o = b_i[0];
            TS_BMSB:  pred_o = b_i[W-1];
            default:  pred_o = sense_i;
        endcase
    end

endmodule

// File: rtl/mm_alu.sv
module mm_alu
    import mm_alu_pkg::*;
#(
    parameter int unsigned W         = 32,
    parameter int unsigned IMM_SHIFT = 7
) (
    input  logic [W-1:0] ctrl_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] res_o,
    output logic         pred_o
);

    localparam logic SENSE_TIE = 1'b0;

    ctl_t         ctl_d;
    logic [W-1:0] effb_d;

    assign ctl_d = ctl_decode(ctrl_i[6:0]);

    mm_bpre #(.W(W), .IMM_SHIFT(IMM_SHIFT)) u_bpre (
        .opb_i  (opb_i),
        .ctrl_i (ctrl_i),
        .bsel_i (ctl_d.bsel),
        .inv_i  (ctl_d.inv),
        .effb_o (effb_d)
    );

    mm_dfn #(.W(W)) u_dfn (
        .a_i    (opa_i),
        .b_i    (effb_d),
        .cin_i  (ctl_d.cin),
        .code_i (ctl_d.code),
        .res_o  (res_o)
    );

    mm_tfn #(.W(W)) u_tfn (
        .a_i     (opa_i),
        .b_i     (effb_d),
        .code_i  (ctl_d.code),
        .sense_i (SENSE_TIE),
        .pred_o  (pred_o)
    );

endmodule

// File: rtl/mm_alu_chk.sv
module mm_alu_chk #(
    parameter int unsigned W         = 32,
    parameter int unsigned IMM_SHIFT = 7
) (
    input logic [W-1:0] ctrl_i,
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [W-1:0] res_o,
    input logic         pred_o
);

    always_comb begin
        if (ctrl_i[2:1] == 2'b11)
            p_nil_code_r7: assert (res_o == '0) else $error("R7 nonzero result");
        if (ctrl_i[2:0] == 3'd7)
            p_sense_low_r11: assert (!pred_o) else $error("R11 sense true");
        if (ctrl_i[2:0] == 3'd4)
            p_pass_a_r6: assert (res_o == opa_i) else $error("R6 pass A");
        if (ctrl_i[2:0] == 3'd0)
            p_azero_r8: assert (pred_o == (opa_i == '0)) else $error("R8 A zero test");
        if (ctrl_i[6:0] == 7'b0000000)
            p_add_plain_r5: assert (res_o == opa_i + opb_i) else $error("R5 add");
        if (ctrl_i[6:0] == 7'b0000101)
            p_raw_b_r1: assert (res_o == opb_i) else $error("R1 raw B");
        if (ctrl_i[6:0] == 7'b0100101)
            p_imm_b_r2: assert (res_o == (ctrl_i >> IMM_SHIFT)) else $error("R2 imm B");
        if (ctrl_i[6:0] == 7'b0001101)
            p_inv_b_r4: assert (res_o == ~opb_i) else $error("R4 invert");
    end

endmodule

bind mm_alu mm_alu_chk #(.W(W), .IMM_SHIFT(IMM_SHIFT)) u_chk (
    .ctrl_i (ctrl_i),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .res_o  (res_o),
    .pred_o (pred_o)
);

// File: tb/mm_alu_tb.sv
`timescale 1ns/1ps
module mm_alu_tb;

    logic        clk;
    logic        rst;
    logic [31:0] ctrl;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [31:0] res;
    logic        pred;

    int n_cmp;
    int n_bad;
    bit done;

    mm_alu u_dut (
        .ctrl_i (ctrl),
        .opa_i  (opa),
        .opb_i  (opb),
        .res_o  (res),
        .pred_o (pred)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic longint unsigned eff_b(longint unsigned c, longint unsigned b);
        longint unsigned m = 64'hFFFF_FFFF;
        longint unsigned e;
        int sel = int'((c / 32) % 4);
        if (sel == 0)      e = b;
        else if (sel == 1) e = c / 128;
        else if (sel == 2) e = b / 2;
        else               e = (b * 2) & m;
        if (((c / 8) % 2) == 1) e = e ^ m;
        return e;
    endfunction

    function automatic logic [31:0] model_res(longint unsigned c, longint unsigned a, longint unsigned b);
        longint unsigned e = eff_b(c, b);
        int f = int'(c % 8);
        longint unsigned r;
        if (f == 0)      r = (a + e + ((c / 16) % 2)) % 64'h1_0000_0000;
        else if (f == 1) r = a & e;
        else if (f == 2) r = a | e;
        else if (f == 3) r = a ^ e;
        else if (f == 4) r = a;
        else if (f == 5) r = e;
        else             r = 0;
        return r[31:0];
    endfunction

    function automatic logic model_pred(longint unsigned c, longint unsigned a, longint unsigned b);
        longint unsigned e = eff_b(c, b);
        int f = int'(c % 8);
        if (f == 0) return a == 0;
        if (f == 1) return e == 0;
        if (f == 2) return a > e;
        if (f == 3) return a == e;
        if (f == 4) return a < e;
        if (f == 5) return (e % 2) == 1;
        if (f == 6) return e >= 64'h8000_0000;
        return 1'b0;
    endfunction

    function automatic string res_tag(logic [31:0] c);
        if (c[2:0] == 3'd0) return "R5";
        if (c[2:0] >= 3'd6) return "R7";
        return "R6";
    endfunction

    function automatic string pred_tag(logic [31:0] c);
        if (c[2:0] <= 3'd1) return "R8";
        if (c[2:0] <= 3'd4) return "R9";
        if (c[2:0] <= 3'd6) return "R10";
        return "R11";
    endfunction

    task automatic judge(string rt, string pt);
        logic [31:0] er = model_res(longint'(ctrl), longint'(opa), longint'(opb));
        logic        ep = model_pred(longint'(ctrl), longint'(opa), longint'(opb));
        n_cmp++;
        if (res !== er) begin
            n_bad++;
            $display("FAIL %s res ctrl=%h a=%h b=%h actual=%h expected=%h", rt, ctrl, opa, opb, res, er);
        end
        n_cmp++;
        if (pred !== ep) begin
            n_bad++;
            $display("FAIL %s pred ctrl=%h a=%h b=%h actual=%b expected=%b", pt, ctrl, opa, opb, pred, ep);
        end
    endtask

    task automatic apply(logic [31:0] c, logic [31:0] a, logic [31:0] b, string rt, string pt);
        @(negedge clk);
        ctrl = c; opa = a; opb = b;
        #1;
        judge(rt, pt);
    endtask

    task automatic expect_res(logic [31:0] want, string tag);
        n_cmp++;
        if (res !== want) begin
            n_bad++;
            $display("FAIL %s directed actual=%h expected=%h", tag, res, want);
        end
    endtask

    initial begin
        rst = 1'b1;
        ctrl = '0; opa = '0; opb = '0;
        n_cmp = 0; n_bad = 0; done = 0;
        repeat (3) @(posedge clk);
        #1;
        // reset state: all-zero inputs give a zero sum and a true A-zero test (R8)
        expect_res(32'h0, "R5");
        n_cmp++;
        if (pred !== 1'b1) begin
            n_bad++;
            $display("FAIL R8 reset pred actual=%b expected=1", pred);
        end
        rst = 1'b0;

        // R1: raw B through pass-B
        apply(32'h0000_0005, 32'h1111_1111, 32'hDEAD_BEEF, "R1", "R10");
        expect_res(32'hDEAD_BEEF, "R1");
        // R2: control word shifted right by 7
        apply(32'hABCD_EF25, 32'h0, 32'h1234_5678, "R2", "R10");
        expect_res(32'hABCD_EF25 >> 7, "R2");
        // R3: shifts
        apply(32'h0000_0045, 32'h0, 32'h8000_0003, "R3", "R10");
        expect_res(32'h4000_0001, "R3");
        apply(32'h0000_0065, 32'h0, 32'h8000_0003, "R3", "R10");
        expect_res(32'h0000_0006, "R3");
        // R4: inversion after the shift
        apply(32'h0000_006D, 32'h0, 32'h8000_0003, "R4", "R10");
        expect_res(32'hFFFF_FFF9, "R4");
        // R5: wrap and carry-in
        apply(32'h0000_0010, 32'hFFFF_FFFF, 32'h0000_0000, "R5", "R8");
        expect_res(32'h0000_0000, "R5");
        apply(32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0002, "R5", "R8");
        expect_res(32'h0000_0001, "R5");
        // R9: unsigned compare, MSB-set A is greater
        apply(32'h0000_0002, 32'h8000_0000, 32'h7FFF_FFFF, "R6", "R9");
        // R9: compare uses effective B (1 shifted left equals 2)
        apply(32'h0000_0063, 32'h0000_0002, 32'h0000_0001, "R6", "R9");
        // R11: sense stays false with everything set
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7", "R11");

        // R12: change inputs mid-cycle and look before the next edge
        @(negedge clk);
        ctrl = 32'h0000_0004; opa = 32'h0F0F_0F0F; opb = 32'h0;
        #0.5;
        expect_res(32'h0F0F_0F0F, "R12");
        opa = 32'h3333_3333;
        #0.5;
        expect_res(32'h3333_3333, "R12");

        // sweep of every low control pattern against several operand pairs
        for (int lo = 0; lo < 128; lo++) begin
            for (int k = 0; k < 6; k++) begin
                logic [31:0] c = ($urandom() & 32'hFFFF_FF80) | lo;
                logic [31:0] a;
                logic [31:0] b;
                case (k)
                    0: begin a = 32'h0;         b = 32'h0;         end
                    1: begin a = 32'h0000_0005; b = 32'h0000_0005; end
                    2: begin a = 32'hFFFF_FFFF; b = 32'h0000_0001; end
                    3: begin a = 32'h8000_0000; b = 32'h8000_0000; end
                    default: begin a = $urandom(); b = $urandom(); end
                endcase
                apply(c, a, b, res_tag(c), pred_tag(c));
            end
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule